// File: doc/BRIEF.md
# Video Capture Demultiplexer with Horizontal Decimation

This block takes an 8-bit 4:2:2 digital video byte stream of the ITU-R BT.656 kind, one byte per clock. It watches for the four-byte timing reference code and reads the field, vertical-blanking and start/end flags from its last byte. It then splits the interleaved chroma-blue, luma, chroma-red, luma bytes of each active line into three planar sample streams. Each stream has its own one-cycle valid strobe. A shared line-start pulse, field-start pulse and field identifier mark the frame structure for the memory writer downstream.

A half-resolution input drops every second luma sample and every second chroma pair as the bytes arrive. The 4:2:2 relationship between luma and chroma is kept, and no processor has to touch each pixel. The active line width, in luma samples, is a configuration input. The block latches it, together with the half-resolution setting, at each start of active video.

Top module: `yuv_capture_demux`

## Requirements
- R1: While `rstN` is low, every valid output, `lineStart`, `fieldStart` and `fieldId` are 0.
- R2: A timing code is the byte sequence 0xFF, 0x00, 0x00, XY. In XY, bit 6 is the field bit F, bit 5 is the vertical-blanking bit V and bit 4 is H (0 marks start of active video, 1 marks end). A code with H=0 and V=0 opens active video at the following byte. Any other code closes it.
- R3: In full resolution, active bytes come in the repeating order Cb, Y, Cr, Y, with the phase restarted at each opening code. Each sample is on its stream with its valid high in the cycle after its byte was sampled. `lumaIdx` counts luma samples from 0, and `chromaIdx` counts chroma pairs from 0.
- R4: Active video closes after `lineWidth` luma samples. Bytes after that produce no strobe until the next opening code.
- R5: Bytes outside active video produce no strobe. This covers timing codes, horizontal blanking, and lines whose code has V=1.
- R6: With half resolution, only the first luma of each pair and only the chroma of even-numbered pairs are emitted. `lumaIdx` is the pair number and `chromaIdx` is half the pair number. A 720-sample line gives 360 luma, 180 Cb and 180 Cr samples, and a 640-sample line gives 320, 160 and 160.
- R7: `halfRes` and `lineWidth` are sampled only with the XY byte of an opening code. Changing them within a line has no effect on that line.
- R8: `lineStart` is a one-cycle pulse in the cycle after the XY byte of an opening code. `fieldId` then takes that code's F bit and holds it until the next opening code.
- R9: `fieldStart` pulses together with `lineStart` on the first opening code after reset or after any timing code with V=1. It stays low otherwise.
- R10: At most one of `lumaValid`, `cbValid` and `crValid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteIn | input | 8 | Multiplexed 4:2:2 video byte |
| halfRes | input | 1 | 1 halves horizontal resolution |
| lineWidth | input | PIX_W | Active luma samples per line |
| lumaValid | output | 1 | Luma sample strobe |
| lumaData | output | 8 | Luma sample |
| lumaIdx | output | PIX_W | Luma sample index in the line |
| cbValid | output | 1 | Cb sample strobe |
| cbData | output | 8 | Cb sample |
| crValid | output | 1 | Cr sample strobe |
| crData | output | 8 | Cr sample |
| chromaIdx | output | PIX_W | Chroma pair index in the line |
| lineStart | output | 1 | Start-of-active-line pulse |
| fieldStart | output | 1 | First-active-line-of-field pulse |
| fieldId | output | 1 | Field bit of the current line |

## Verification
The bench goes after the line boundary. Bytes are fed beyond the configured width, and a design that miscounted would let extra samples out or cut the last luma sample. It drives blanking lines whose codes have V=1. A detector that ignored V would open active video there and emit samples. It toggles the resolution and width inputs in the middle of a line, which catches a design that reads them live and switches decimation partway through. It also runs full 720- and 640-sample lines at half resolution. Keeping odd pairs, or the wrong luma of a pair, shifts the indices and the per-stream counts away from 360/180/180 and 320/160/160.

// File: rtl/yuv_capture_pkg.sv
package yuv_capture_pkg;

  localparam logic [7:0] CODE_LEAD = 8'hFF;
  localparam logic [7:0] CODE_ZERO = 8'h00;
  localparam int XY_FIELD_BIT = 6;
  localparam int XY_VBLANK_BIT = 5;
  localparam int XY_HEND_BIT = 4;

  typedef struct packed {
    logic lumaStb;
    logic cbStb;
    logic crStb;
    logic lineStb;
    logic fieldStb;
    logic fieldBit;
  } capStrobes_t;

endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import yuv_capture_pkg::*;
#(
  parameter int PIX_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       byteIn,
  input  logic             halfRes,
  input  logic [PIX_W-1:0] lineWidth,
  output capStrobes_t      stb,
  output logic [PIX_W-1:0] lumaIdxNext,
  output logic [PIX_W-1:0] chromaIdxNext
);

  localparam int HIST_LEN = 3;
  localparam logic [PIX_W-1:0] ONE = PIX_W'(1);

  logic [HIST_LEN-1:0][7:0] hist;
  logic                     active;
  logic [1:0]               phase;
  logic [PIX_W-1:0]         pairCnt;
  logic                     latHalf;
  logic [PIX_W-1:0]         latWidth;
  logic                     sawBlank;

  logic             codeSeen;
  logic             isOpen;
  logic             inData;
  logic [PIX_W-1:0] pixNow;
  logic             lumaKeep;
  logic             chromaKeep;
  logic             lastPix;

  always_comb begin
    codeSeen   = (hist[2] == CODE_LEAD) && (hist[1] == CODE_ZERO) && (hist[0] == CODE_ZERO);
    isOpen     = codeSeen && !byteIn[XY_HEND_BIT] && !byteIn[XY_VBLANK_BIT];
    inData     = active && !codeSeen;
    pixNow     = {pairCnt[PIX_W-2:0], phase[1]};
    lumaKeep   = inData && phase[0] && (!latHalf || !phase[1]);
    chromaKeep = inData && !phase[0] && (!latHalf || !pairCnt[0]);
    lastPix    = inData && phase[0] && (pixNow == latWidth - ONE);

    stb.lumaStb  = lumaKeep;
    stb.cbStb    = chromaKeep && !phase[1];
    stb.crStb    = chromaKeep && phase[1];
    stb.lineStb  = isOpen;
    stb.fieldStb = isOpen && sawBlank;
    stb.fieldBit = byteIn[XY_FIELD_BIT];

    lumaIdxNext   = latHalf ? pairCnt : pixNow;
    chromaIdxNext = latHalf ? (pairCnt >> 1) : pairCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist     <= '0;
      active   <= 1'b0;
      phase    <= 2'd0;
      pairCnt  <= '0;
      latHalf  <= 1'b0;
      latWidth <= '0;
      sawBlank <= 1'b1;
    end else begin
      hist <= {hist[1:0], byteIn};
      if (codeSeen) begin
        active  <= isOpen;
        phase   <= 2'd0;
        pairCnt <= '0;
        if (isOpen) begin
          latHalf  <= halfRes;
          latWidth <= lineWidth;
          sawBlank <= 1'b0;
        end else if (byteIn[XY_VBLANK_BIT]) begin
          sawBlank <= 1'b1;
        end
      end else if (active) begin
        phase <= phase + 2'd1;
        if (phase == 2'd3) pairCnt <= pairCnt + ONE;
        if (lastPix) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/capture_datapath.sv
module capture_datapath
  import yuv_capture_pkg::*;
#(
  parameter int PIX_W = 11,
  parameter int CHROMA_LANES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [7:0]                   byteIn,
  input  capStrobes_t                  stb,
  input  logic [PIX_W-1:0]             lumaIdxNext,
  input  logic [PIX_W-1:0]             chromaIdxNext,
  output logic                         lumaValid,
  output logic [7:0]                   lumaData,
  output logic [PIX_W-1:0]             lumaIdx,
  output logic [CHROMA_LANES-1:0]      chromaValid,
  output logic [CHROMA_LANES-1:0][7:0] chromaData,
  output logic [PIX_W-1:0]             chromaIdx,
  output logic                         lineStart,
  output logic                         fieldStart,
  output logic                         fieldId
);

  logic [CHROMA_LANES-1:0] laneStb;
  assign laneStb = {stb.crStb, stb.cbStb};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lumaValid  <= 1'b0;
      lumaData   <= '0;
      lumaIdx    <= '0;
      chromaIdx  <= '0;
      lineStart  <= 1'b0;
      fieldStart <= 1'b0;
      fieldId    <= 1'b0;
    end else begin
      lumaValid  <= stb.lumaStb;
      lineStart  <= stb.lineStb;
      fieldStart <= stb.fieldStb;
      if (stb.lumaStb) begin
        lumaData <= byteIn;
        lumaIdx  <= lumaIdxNext;
      end
      if (|laneStb) chromaIdx <= chromaIdxNext;
      if (stb.lineStb) fieldId <= stb.fieldBit;
    end
  end

  for (genvar c = 0; c < CHROMA_LANES; c++) begin : g_lane
    logic       validQ;
    logic [7:0] dataQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        dataQ  <= '0;
      end else begin
        validQ <= laneStb[c];
        if (laneStb[c]) dataQ <= byteIn;
      end
    end
    assign chromaValid[c] = validQ;
    assign chromaData[c]  = dataQ;
  end

endmodule

// File: rtl/yuv_capture_demux.sv
module yuv_capture_demux
  import yuv_capture_pkg::*;
#(
  parameter int PIX_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       byteIn,
  input  logic             halfRes,
  input  logic [PIX_W-1:0] lineWidth,
  output logic             lumaValid,
  output logic [7:0]       lumaData,
  output logic [PIX_W-1:0] lumaIdx,
  output logic             cbValid,
  output logic [7:0]       cbData,
  output logic             crValid,
  output logic [7:0]       crData,
  output logic [PIX_W-1:0] chromaIdx,
  output logic             lineStart,
  output logic             fieldStart,
  output logic             fieldId
);

  capStrobes_t      stb;
  logic [PIX_W-1:0] lumaIdxNext;
  logic [PIX_W-1:0] chromaIdxNext;
  logic [1:0]       chromaValid;
  logic [1:0][7:0]  chromaData;

  capture_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .byteIn       (byteIn),
    .halfRes      (halfRes),
    .lineWidth    (lineWidth),
    .stb          (stb),
    .lumaIdxNext  (lumaIdxNext),
    .chromaIdxNext(chromaIdxNext)
  );

  capture_datapath #(.PIX_W(PIX_W), .CHROMA_LANES(2)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .byteIn       (byteIn),
    .stb          (stb),
    .lumaIdxNext  (lumaIdxNext),
    .chromaIdxNext(chromaIdxNext),
    .lumaValid    (lumaValid),
    .lumaData     (lumaData),
    .lumaIdx      (lumaIdx),
    .chromaValid  (chromaValid),
    .chromaData   (chromaData),
    .chromaIdx    (chromaIdx),
    .lineStart    (lineStart),
    .fieldStart   (fieldStart),
    .fieldId      (fieldId)
  );

  assign cbValid = chromaValid[0];
  assign cbData  = chromaData[0];
  assign crValid = chromaValid[1];
  assign crData  = chromaData[1];

endmodule

// File: rtl/yuv_capture_demux_chk.sv
module yuv_capture_demux_chk #(
  parameter int PIX_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             lumaValid,
  input logic             cbValid,
  input logic             crValid,
  input logic [PIX_W-1:0] chromaIdx,
  input logic             lineStart,
  input logic             fieldStart,
  input logic             fieldId
);

  // R1: outputs quiet while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_reset_quiet_r1: assert (!lumaValid && !cbValid && !crValid && !lineStart && !fieldStart && !fieldId);
    end
  end

  p_single_stream_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lumaValid, cbValid, crValid}));

  p_line_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !lineStart);

  p_field_id_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |-> $stable(fieldId));

  p_field_with_line_r9: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |-> lineStart);

  p_open_then_cb_r2: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> cbValid);

  p_cb_then_luma_r3: assert property (@(posedge clk) disable iff (!rstN)
    cbValid |=> lumaValid);

  p_cr_follows_cb_r3: assert property (@(posedge clk) disable iff (!rstN)
    crValid |-> ($past(cbValid, 2) && chromaIdx == $past(chromaIdx, 2)));

endmodule

bind yuv_capture_demux yuv_capture_demux_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lumaValid (lumaValid),
  .cbValid   (cbValid),
  .crValid   (crValid),
  .chromaIdx (chromaIdx),
  .lineStart (lineStart),
  .fieldStart(fieldStart),
  .fieldId   (fieldId)
);

// File: tb/yuv_capture_demux_test.sv
`timescale 1ns/1ps
module yuv_capture_demux_test;

  localparam int PIX_W = 11;

  logic             clk = 1'b0;
  logic             rstN;
  logic [7:0]       byteIn;
  logic             halfRes;
  logic [PIX_W-1:0] lineWidth;
  logic             lumaValid, cbValid, crValid;
  logic [7:0]       lumaData, cbData, crData;
  logic [PIX_W-1:0] lumaIdx, chromaIdx;
  logic             lineStart, fieldStart, fieldId;

  always #2.5 clk = ~clk;

  yuv_capture_demux #(.PIX_W(PIX_W)) uut (.*);

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string curTag = "R1";

  // reference model state
  int h0 = 0, h1 = 0, h2 = 0;
  bit mActive = 0, mHalf = 0, mBlank = 1;
  int mWidth = 0, mByteNo = 0;
  bit eL = 0, eCb = 0, eCr = 0, eLS = 0, eFS = 0, eFid = 0;
  int eLD, eCbD, eCrD, eLIdx, eCIdx;
  int cntL = 0, cntCb = 0, cntCr = 0;
  int seed = 7;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    string sTag;
    sTag = rstN ? curTag : "R1";
    cmp(sTag, "lumaValid", lumaValid, eL);
    cmp(sTag, "cbValid", cbValid, eCb);
    cmp(sTag, "crValid", crValid, eCr);
    cmp(rstN ? "R10" : "R1", "one stream", int'(lumaValid) + int'(cbValid) + int'(crValid) <= 1, 1);
    cmp(rstN ? "R8" : "R1", "lineStart", lineStart, eLS);
    cmp(rstN ? "R9" : "R1", "fieldStart", fieldStart, eFS);
    cmp(rstN ? "R8" : "R1", "fieldId", fieldId, eFid);
    if (eL && lumaValid) begin
      cmp(sTag, "lumaData", lumaData, eLD);
      cmp(sTag, "lumaIdx", lumaIdx, eLIdx);
    end
    if (eCb && cbValid) begin
      cmp(sTag, "cbData", cbData, eCbD);
      cmp(sTag, "chromaIdx", chromaIdx, eCIdx);
    end
    if (eCr && crValid) begin
      cmp(sTag, "crData", crData, eCrD);
      cmp(sTag, "chromaIdx", chromaIdx, eCIdx);
    end
    cntL += lumaValid;
    cntCb += cbValid;
    cntCr += crValid;
  endtask

  task automatic modelStep(input int b);
    bit isCode;
    int ph, pair, pix;
    isCode = (h2 == 255 && h1 == 0 && h0 == 0);
    eL = 0; eCb = 0; eCr = 0; eLS = 0; eFS = 0;
    if (isCode) begin
      mActive = 0;
      if (((b >> 5) & 1) == 1) mBlank = 1;
      if (((b >> 4) & 1) == 0 && ((b >> 5) & 1) == 0) begin
        mActive = 1;
        mByteNo = 0;
        mHalf = halfRes;
        mWidth = lineWidth;
        eLS = 1;
        eFS = mBlank;
        mBlank = 0;
        eFid = (b >> 6) & 1;
      end
    end else if (mActive) begin
      ph = mByteNo % 4;
      pair = mByteNo / 4;
      if (ph == 0 || ph == 2) begin
        if (!mHalf || pair % 2 == 0) begin
          if (ph == 0) begin eCb = 1; eCbD = b; end
          else begin eCr = 1; eCrD = b; end
          eCIdx = mHalf ? pair / 2 : pair;
        end
      end else begin
        pix = 2 * pair + (ph == 3 ? 1 : 0);
        if (!mHalf || ph == 1) begin
          eL = 1; eLD = b;
          eLIdx = mHalf ? pair : pix;
        end
        if (pix == mWidth - 1) mActive = 0;
      end
      mByteNo++;
    end
    h2 = h1; h1 = h0; h0 = b;
  endtask

  task automatic sendByte(input int b);
    @(negedge clk);
    checkOutputs();
    byteIn = b[7:0];
    modelStep(b);
  endtask

  task automatic sendCode(input bit f, input bit v, input bit h);
    logic [7:0] xy;
    xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    sendByte(255); sendByte(0); sendByte(0); sendByte(int'(xy));
  endtask

  task automatic sendBlank(input int n);
    for (int i = 0; i < n; i++) sendByte((i % 2 == 0) ? 128 : 16);
  endtask

  task automatic sendData(input int n);
    for (int i = 0; i < n; i++) begin
      seed = (seed * 75 + 74) % 65537;
      sendByte(1 + seed % 254);
    end
  endtask

  task automatic sendActiveLine(input bit f, input int n);
    sendCode(f, 0, 1);
    sendBlank(8);
    sendCode(f, 0, 0);
    sendData(n);
  endtask

  task automatic sendBlankLine(input bit f);
    sendCode(f, 1, 1);
    sendBlank(8);
    sendCode(f, 1, 0);
    sendData(24);
  endtask

  task automatic countLine(input int w, input int expL, input int expC);
    lineWidth = w[PIX_W-1:0];
    halfRes = 1;
    sendCode(0, 0, 1);
    sendBlank(8);
    cntL = 0; cntCb = 0; cntCr = 0;
    sendCode(0, 0, 0);
    sendData(2 * w);
    sendCode(0, 0, 1);
    sendBlank(4);
    cmp("R6", "luma count", cntL, expL);
    cmp("R6", "cb count", cntCb, expC);
    cmp("R6", "cr count", cntCr, expC);
  endtask

  initial begin
    rstN = 0; byteIn = 0; halfRes = 0; lineWidth = 16;
    curTag = "R1";
    repeat (3) begin @(negedge clk); checkOutputs(); end
    rstN = 1;

    curTag = "R5"; sendBlankLine(0); sendBlankLine(0);
    curTag = "R2"; sendActiveLine(0, 32);
    curTag = "R3"; sendActiveLine(0, 32);
    curTag = "R4"; lineWidth = 10; sendActiveLine(0, 48);
    curTag = "R6"; lineWidth = 16; halfRes = 1; sendActiveLine(0, 32);
    // R7: settings change in mid-line must not alter the running line
    curTag = "R7"; halfRes = 0; lineWidth = 16;
    sendCode(0, 0, 1); sendBlank(8); sendCode(0, 0, 0);
    sendData(6);
    halfRes = 1; lineWidth = 8;
    sendData(34);
    curTag = "R5"; sendBlankLine(1);
    curTag = "R9"; halfRes = 0; lineWidth = 12; sendActiveLine(1, 24);
    curTag = "R6";
    countLine(720, 360, 180);
    countLine(640, 320, 160);
    sendBlank(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule